// File: doc/BRIEF.md
# Multi-mode debug cycle counter

This block is a debug support register that serves one of three functions, chosen by a 2-bit mode input. As a stopwatch it counts clock cycles while the processor runs between two halts. As a countdown it decrements toward zero while the processor runs and asks for a break when it arrives there. As an address comparator it keeps its value fixed and asks for a break when the program counter equals it.

The debug-mode flag gates every function. The count advances only while the flag is low. A falling edge of the flag marks a resume, and in stopwatch mode it clears the register. A host may write the register only while the flag is high. The break request is a registered one-cycle pulse. The instruction decoder and the host link lie outside this block.

Top module: `dbg_cntr`

## Requirements
- R1: While rst_ni is low, cnt_o is 0 and brk_o is 0.
- R2: When dbg_mode_i and wr_en_i are both high in a cycle, cnt_o equals wr_data_i in the next cycle, whatever the mode. A load never produces a break pulse.
- R3: A write with dbg_mode_i low is ignored. cnt_o then follows only the rules of the current mode.
- R4: In stopwatch mode (mode_i = 2'b00), cnt_o rises by one in each cycle that dbg_mode_i is low, and it holds while dbg_mode_i is high.
- R5: In stopwatch mode, in the first cycle with dbg_mode_i low after a cycle with it high, the register clears to 0 instead of incrementing.
- R6: In stopwatch mode, cnt_o saturates at all-ones and does not wrap.
- R7: In countdown mode (mode_i = 2'b01), cnt_o falls by one in each cycle that dbg_mode_i is low and cnt_o is nonzero. It is not cleared on resume, and it keeps its remaining value while dbg_mode_i is high.
- R8: In countdown mode, brk_o is high for exactly one cycle, and that is the first cycle in which cnt_o shows 0 after a decrement. Afterwards cnt_o stays at 0 and gives no further pulses.
- R9: In match mode (mode_i = 2'b10), cnt_o is held. brk_o rises one cycle after the first of a run of consecutive cycles in which dbg_mode_i is low and pc_i equals cnt_o, and it lasts one cycle for each such run.
- R10: With mode_i = 2'b11 the register holds and no break is produced.
- R11: brk_o is never high in the cycle after a cycle with dbg_mode_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_mode_i | input | 1 | High while the processor is halted in debug mode |
| pc_i | input | CNT_W | Current program counter |
| mode_i | input | 2 | Function select: 00 stopwatch, 01 countdown, 10 match, 11 hold |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | CNT_W | Host load value |
| cnt_o | output | CNT_W | Current register value |
| brk_o | output | 1 | One-cycle break request |

## Verification
The bench builds the block with CNT_W = 8. At that width, saturation at all-ones comes within a few hundred running cycles, and random program counter values land on the register value often enough to produce many match pulses. The random phase switches mode, the debug flag and host writes at random, so mode changes next to pulses, and writes made while running, are also exercised against the bench model.

// File: rtl/dbg_cntr_pkg.sv
package dbg_cntr_pkg;
  typedef enum logic [1:0] {
    MODE_CYC   = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_MATCH = 2'b10,
    MODE_HOLD  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/dbg_cntr_phase.sv
module dbg_cntr_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbg_mode_i,
  output logic run_o,
  output logic exit_o
);
  logic dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbg_q <= 1'b0;
    else         dbg_q <= dbg_mode_i;
  end

  assign run_o  = ~dbg_mode_i;
  assign exit_o = dbg_q & ~dbg_mode_i;
endmodule

// File: rtl/dbg_cntr_reg.sv
module dbg_cntr_reg
  import dbg_cntr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic             run_i,
  input  logic             exit_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax  = '1;
  localparam logic [CNT_W-1:0] CntZero = '0;
  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      case (mode_i)
        MODE_CYC: begin
          if (exit_i)                         cnt_d = CntZero;
          else if (run_i && cnt_q != CntMax)  cnt_d = cnt_q + CntOne;
        end
        MODE_DOWN: begin
          if (run_i && cnt_q != CntZero)      cnt_d = cnt_q - CntOne;
        end
        default: ;  // match and hold keep the value
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CntZero;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbg_cntr_brk.sv
module dbg_cntr_brk
  import dbg_cntr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] pc_i,
  output logic             brk_o
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic down_hit, pc_hit, pc_hit_q, brk_q;

  // countdown fires on the decrement that lands on zero
  assign down_hit = run_i && (mode_i == MODE_DOWN) && (cnt_i == CntOne);
  assign pc_hit   = run_i && (mode_i == MODE_MATCH) && (pc_i == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_hit_q <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      pc_hit_q <= pc_hit;
      brk_q    <= down_hit | (pc_hit & ~pc_hit_q);
    end
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/dbg_cntr.sv
module dbg_cntr
  import dbg_cntr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbg_mode_i,
  input  logic [CNT_W-1:0] pc_i,
  input  logic [1:0]       mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             brk_o
);
  cnt_mode_e        mode;
  logic             run, exit_dbg, load;
  logic [CNT_W-1:0] cnt;

  assign mode = cnt_mode_e'(mode_i);
  assign load = dbg_mode_i & wr_en_i;

  dbg_cntr_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_mode_i (dbg_mode_i),
    .run_o      (run),
    .exit_o     (exit_dbg)
  );

  dbg_cntr_reg #(.CNT_W(CNT_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .run_i      (run),
    .exit_i     (exit_dbg),
    .load_i     (load),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt)
  );

  dbg_cntr_brk #(.CNT_W(CNT_W)) u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .run_i  (run),
    .cnt_i  (cnt),
    .pc_i   (pc_i),
    .brk_o  (brk_o)
  );

  assign cnt_o = cnt;
endmodule

// File: rtl/dbg_cntr_chk.sv
module dbg_cntr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_mode_i,
  input logic [CNT_W-1:0] pc_i,
  input logic [1:0]       mode_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             brk_o
);
  localparam logic [CNT_W-1:0] Max = '1;
  logic started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (cnt_o == '0 && !brk_o); // R1
  end

  AST_HOST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i && wr_en_i) |=> (cnt_o == $past(wr_data_i) && !brk_o)); // R2

  AST_CYC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && mode_i == 2'b00 && !dbg_mode_i && $past(dbg_mode_i)) |=> cnt_o == '0); // R5

  AST_CYC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && mode_i == 2'b00 && !dbg_mode_i && !$past(dbg_mode_i) && cnt_o == Max)
    |=> cnt_o == Max); // R6

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !dbg_mode_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1); // R7

  AST_DOWN_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && mode_i == 2'b01) |=> (mode_i != 2'b01 || !brk_o)); // R8

  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_mode_i && mode_i == 2'b10) |=> $stable(cnt_o)); // R9

  AST_MATCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && brk_o && $past(mode_i) == 2'b10) |-> $past(pc_i) == $past(cnt_o)); // R9

  AST_HOLD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_mode_i && mode_i == 2'b11) |=> ($stable(cnt_o) && !brk_o)); // R10

  AST_NO_BRK_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && $past(dbg_mode_i)) |-> !brk_o); // R11
endmodule

bind dbg_cntr dbg_cntr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbg_mode_i (dbg_mode_i),
  .pc_i       (pc_i),
  .mode_i     (mode_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .cnt_o      (cnt_o),
  .brk_o      (brk_o)
);

// File: tb/dbg_cntr_bench.sv
module dbg_cntr_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dbg = 1'b1;
  logic [W-1:0] pc = '0;
  logic [1:0]   mode = 2'b00;
  logic         wr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] cnt;
  logic         brk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [W-1:0] m_cnt = '0;
  logic         m_dbgq = 1'b0;
  logic         m_hitq = 1'b0;
  logic         m_brk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cntr #(.CNT_W(W)) u_dbg_cntr (
    .clk_i(clk), .rst_ni(rst_n), .dbg_mode_i(dbg), .pc_i(pc), .mode_i(mode),
    .wr_en_i(wr), .wr_data_i(wd), .cnt_o(cnt), .brk_o(brk)
  );

  function automatic logic [W-1:0] f_cnt(logic [W-1:0] c, logic dq, logic d,
                                         logic [1:0] md, logic we, logic [W-1:0] v);
    if (d && we) return v;
    if (md == 2'b00) begin
      if (dq && !d) return '0;
      if (!d && c != {W{1'b1}}) return c + 1'b1;
    end else if (md == 2'b01) begin
      if (!d && c != '0) return c - 1'b1;
    end
    return c;
  endfunction

  function automatic logic f_hit(logic [W-1:0] c, logic d, logic [1:0] md, logic [W-1:0] p);
    return !d && md == 2'b10 && p == c;
  endfunction

  function automatic logic f_brk(logic [W-1:0] c, logic d, logic [1:0] md,
                                 logic [W-1:0] p, logic hq);
    return (!d && md == 2'b01 && c == W'(1)) || (f_hit(c, d, md, p) && !hq);
  endfunction

  task automatic check(string tag);
    checks++;
    if (cnt !== m_cnt || brk !== m_brk) begin
      errors++;
      $display("FAIL %s: cnt=%0h brk=%0b expected cnt=%0h brk=%0b", tag, cnt, brk, m_cnt, m_brk);
    end
  endtask

  // inputs are set at a negedge; model advances, edge passes, compare at next negedge
  task automatic step(string tag);
    logic h;
    m_brk  = f_brk(m_cnt, dbg, mode, pc, m_hitq);
    h      = f_hit(m_cnt, dbg, mode, pc);
    m_cnt  = f_cnt(m_cnt, m_dbgq, dbg, mode, wr, wd);
    m_hitq = h;
    m_dbgq = dbg;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    check(tag);
  endtask

  task automatic load(logic [1:0] md, logic [W-1:0] v);
    dbg = 1'b1; mode = md; wr = 1'b1; wd = v;
    step("R2");
    wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step("R1");

    // stopwatch
    load(2'b00, 8'h5A);
    dbg = 1'b0;
    step("R5");
    for (int i = 0; i < 4; i++) step("R4");
    dbg = 1'b1;
    repeat (2) step("R4");
    dbg = 1'b0;
    step("R5");
    repeat (300) step("R6");

    // writes while running are dropped
    mode = 2'b11; wr = 1'b1; wd = 8'h33;
    repeat (3) step("R3");
    wr = 1'b0;
    repeat (2) step("R10");

    // countdown to zero
    load(2'b01, 8'd5);
    dbg = 1'b0;
    repeat (4) step("R7");
    step("R8");
    repeat (4) step("R8");
    // halt mid-way
    load(2'b01, 8'd10);
    dbg = 1'b0;
    repeat (3) step("R7");
    dbg = 1'b1;
    repeat (3) step("R7");
    dbg = 1'b0; wr = 1'b1; wd = 8'h02;
    step("R3");
    wr = 1'b0;
    repeat (8) step("R8");

    // match
    load(2'b10, 8'h40);
    pc = 8'h3F;
    step("R11");
    dbg = 1'b0;
    pc = 8'h10;
    repeat (2) step("R9");
    pc = 8'h40;
    repeat (4) step("R9");
    pc = 8'h41;
    step("R9");
    pc = 8'h40;
    repeat (2) step("R9");
    dbg = 1'b1;
    repeat (3) step("R11");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) dbg = ~dbg;
      if ($urandom % 32 == 0) mode = 2'($urandom);
      wr = ($urandom % 6 == 0);
      wd = ($urandom % 2) ? W'($urandom % 8) : W'($urandom);
      pc = ($urandom % 3 == 0) ? m_cnt : W'($urandom);
      step(dbg ? "R11" : "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule